// File: doc/BRIEF.md
# Bus-Attached Bidirectional Pin Port

This block is an eight-pin general-purpose I/O port that sits as a slave on a 32-bit processor bus. The master addresses it by a 30-bit word address, and two words of the address space belong to the port. The word at the base holds the pin values and the word one above it holds the per-pin direction bits. Every access uses a four-phase handshake. The master places address, byte enables, the read/not-write flag and any write data on the bus, then raises the master enable. The port performs the access and raises its acknowledge. The master then lowers the enable, and only after that does the port lower the acknowledge.

On the pin side each pad is modelled as three signals: a value to drive, an enable for the driver, and the level seen at the pad. A pin whose direction bit is set drives the stored value bit. A pin whose direction bit is clear is left undriven. Reading the value word returns the pad levels after a two-stage synchronizer, so a pin set as an output reads back what it drives.

The control is a two-state machine. In `HS_IDLE` the port waits. The transition *accept* goes from `HS_IDLE` to `HS_ACKING` and is taken on a clock edge where the master enable is high and the address hits one of the port's words. On that same edge any write is performed and any read data is captured. The machine *holds* in `HS_ACKING`, with acknowledge high, for as long as the enable stays high. The transition *release* goes back to `HS_IDLE` on the first edge where the enable is seen low, and it clears the read data.

Top module: `bidir_pin_port`

## Requirements
- R1: After reset the value and direction registers are zero: `pad_oe_o` = 0, `pad_out_o` = 0, `ack_o` = 0 and `rdata_o` = 0.
- R2: While `me_i` is 0 the port does not raise `ack_o` and changes no register, whatever is on the address, data, byte-enable and read/not-write lines.
- R3: A write (`rnw_i` = 0) to word `BASE_WORD` with `be_i[0]` = 1 loads `wdata_i[7:0]` into the value register, and `pad_out_o` shows it when `ack_o` rises.
- R4: A write to word `BASE_WORD+1` with `be_i[0]` = 1 loads `wdata_i[7:0]` into the direction register. For each pin, `pad_oe_o[i]` = 1 (output) or 0 (input, undriven) follows that bit.
- R5: A write with `be_i[0]` = 0 is acknowledged but leaves the addressed register unchanged.
- R6: A read (`rnw_i` = 1) of word `BASE_WORD+1` returns the direction register in `rdata_o[7:0]`, with `rdata_o[31:8]` = 0, while `ack_o` is high.
- R7: A read of word `BASE_WORD` returns in `rdata_o[7:0]` the pad levels `pad_in_i` as seen through the two-stage synchronizer, with upper bits 0.
- R8: `ack_o` rises on the first clock edge that samples `me_i` high with a hitting address. It stays high while `me_i` stays high, and it falls on the first edge that samples `me_i` low.
- R9: Each access is acknowledged exactly once: holding `me_i` high keeps a single acknowledge pulse, and the acknowledge never drops and rises again while `me_i` stays high.
- R10: An access to any word other than `BASE_WORD` and `BASE_WORD+1` is never acknowledged and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 30 | Word address (byte address bits 31:2) |
| wdata_i | input | 32 | Write data from master |
| be_i | input | 4 | Byte enables, one per byte lane |
| rnw_i | input | 1 | 1 = read, 0 = write |
| me_i | input | 1 | Master enable strobe |
| rdata_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Acknowledge |
| pad_in_i | input | 8 | Levels seen at the pads |
| pad_out_o | output | 8 | Values to drive on the pads |
| pad_oe_o | output | 8 | Per-pin driver enable, 1 = output |

## Verification
The machine can get stuck in `HS_ACKING` or miss the *release*. At the ports this shows as `ack_o` staying high one cycle after `me_i` is seen low, or as a second acknowledge in the same access. Both are visible within one cycle of the faulty edge. A corrupted value or direction register shows at once on `pad_out_o` or `pad_oe_o`. It also shows in the very next read of either word. A wrong synchronizer path or read mux shows only in read data, two cycles after the pad levels settle.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
    typedef enum logic [0:0] {
        HS_IDLE   = 1'b0,
        HS_ACKING = 1'b1
    } hs_state_e;

    localparam int unsigned DEF_PIN_W  = 8;
    localparam int unsigned DEF_BUS_W  = 32;
    localparam int unsigned DEF_ADDR_W = 30;
    localparam int unsigned DEF_BE_W   = 4;
endpackage

// File: rtl/pinport_sync.sv
module pinport_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[s] <= '0;
                else         stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinport_hs_fsm.sv
module pinport_hs_fsm
    import pinport_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic me_i,
    input  logic hit_i,
    output logic accept_o,
    output logic release_o,
    output logic ack_o
);
    hs_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= HS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        accept_o  = 1'b0;
        release_o = 1'b0;
        ack_o     = 1'b0;
        unique case (state_q)
            HS_IDLE: begin
                if (me_i && hit_i) begin
                    accept_o = 1'b1;
                    state_d  = HS_ACKING;
                end
            end
            HS_ACKING: begin
                ack_o = 1'b1;
                if (!me_i) begin
                    release_o = 1'b1;
                    state_d   = HS_IDLE;
                end
            end
            default: state_d = HS_IDLE;
        endcase
    end
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs #(
    parameter int unsigned PIN_W = 8,
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             accept_i,
    input  logic             release_i,
    input  logic             rnw_i,
    input  logic             lane0_i,
    input  logic             sel_dir_i,
    input  logic [PIN_W-1:0] wbyte_i,
    input  logic [PIN_W-1:0] pins_sync_i,
    output logic [PIN_W-1:0] value_o,
    output logic [PIN_W-1:0] dir_o,
    output logic [BUS_W-1:0] rdata_o
);
    localparam int unsigned PAD_W = BUS_W - PIN_W;

    logic [PIN_W-1:0] value_q, dir_q;
    logic [BUS_W-1:0] rdata_q;
    logic             wr_en;

    assign wr_en = accept_i && !rnw_i && lane0_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            value_q <= '0;
            dir_q   <= '0;
        end else if (wr_en) begin
            if (sel_dir_i) dir_q   <= wbyte_i;
            else           value_q <= wbyte_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (accept_i && rnw_i) begin
            rdata_q <= {{PAD_W{1'b0}}, (sel_dir_i ? dir_q : pins_sync_i)};
        end else if (release_i) begin
            rdata_q <= '0;
        end
    end

    assign value_o = value_q;
    assign dir_o   = dir_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/bidir_pin_port.sv
module bidir_pin_port
    import pinport_pkg::*;
#(
    parameter int unsigned            PIN_W       = DEF_PIN_W,
    parameter int unsigned            BUS_W       = DEF_BUS_W,
    parameter int unsigned            ADDR_W      = DEF_ADDR_W,
    parameter int unsigned            BE_W        = DEF_BE_W,
    parameter int unsigned            SYNC_STAGES = 2,
    parameter logic [DEF_ADDR_W-1:0]  BASE_WORD   = 30'h4000018
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic [BE_W-1:0]   be_i,
    input  logic              rnw_i,
    input  logic              me_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic              ack_o,
    input  logic [PIN_W-1:0]  pad_in_i,
    output logic [PIN_W-1:0]  pad_out_o,
    output logic [PIN_W-1:0]  pad_oe_o
);
    localparam logic [ADDR_W-1:0] VALUE_WORD = ADDR_W'(BASE_WORD);
    localparam logic [ADDR_W-1:0] DIR_WORD   = ADDR_W'(BASE_WORD) + ADDR_W'(1);

    logic             hit_value, hit_dir, hit;
    logic             accept, release_acc;
    logic [PIN_W-1:0] pins_sync;
    logic             unused_bus_hi;

    assign hit_value     = (addr_i == VALUE_WORD);
    assign hit_dir       = (addr_i == DIR_WORD);
    assign hit           = hit_value || hit_dir;
    assign unused_bus_hi = ^{wdata_i[BUS_W-1:PIN_W], be_i[BE_W-1:1]};

    pinport_hs_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .me_i      (me_i),
        .hit_i     (hit),
        .accept_o  (accept),
        .release_o (release_acc),
        .ack_o     (ack_o)
    );

    pinport_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pad_in_i),
        .q_o    (pins_sync)
    );

    pinport_regs #(
        .PIN_W (PIN_W),
        .BUS_W (BUS_W)
    ) u_regs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .accept_i    (accept),
        .release_i   (release_acc),
        .rnw_i       (rnw_i),
        .lane0_i     (be_i[0]),
        .sel_dir_i   (hit_dir),
        .wbyte_i     (wdata_i[PIN_W-1:0]),
        .pins_sync_i (pins_sync),
        .value_o     (pad_out_o),
        .dir_o       (pad_oe_o),
        .rdata_o     (rdata_o)
    );
endmodule

// File: rtl/bidir_pin_port_chk.sv
module bidir_pin_port_chk #(
    parameter int unsigned       PIN_W     = 8,
    parameter int unsigned       BUS_W     = 32,
    parameter int unsigned       ADDR_W    = 30,
    parameter int unsigned       BE_W      = 4,
    parameter logic [ADDR_W-1:0] BASE_WORD = 30'h4000018
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic [BUS_W-1:0]  wdata_i,
    input logic [BE_W-1:0]   be_i,
    input logic              rnw_i,
    input logic              me_i,
    input logic [BUS_W-1:0]  rdata_o,
    input logic              ack_o,
    input logic [PIN_W-1:0]  pad_out_o,
    input logic [PIN_W-1:0]  pad_oe_o
);
    p_no_ack_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!me_i && !ack_o) |=> !ack_o);

    p_regs_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !me_i |=> ($stable(pad_out_o) && $stable(pad_oe_o)));

    p_value_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(ack_o) && !$past(rnw_i) && $past(be_i[0]) && ($past(addr_i) == BASE_WORD))
        |-> (pad_out_o == $past(wdata_i[PIN_W-1:0])));

    p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> (rdata_o[BUS_W-1:PIN_W] == '0));

    p_ack_needs_me_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) |-> $past(me_i));

    p_ack_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && me_i) |=> ack_o);

    p_ack_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o && !me_i) |=> !ack_o);

    p_hit_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ack_o) |-> (($past(addr_i) == BASE_WORD) || ($past(addr_i) == BASE_WORD + 1'b1)));
endmodule

bind bidir_pin_port bidir_pin_port_chk #(
    .PIN_W     (PIN_W),
    .BUS_W     (BUS_W),
    .ADDR_W    (ADDR_W),
    .BE_W      (BE_W),
    .BASE_WORD (ADDR_W'(BASE_WORD))
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .be_i      (be_i),
    .rnw_i     (rnw_i),
    .me_i      (me_i),
    .rdata_o   (rdata_o),
    .ack_o     (ack_o),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
);

// File: tb/bidir_pin_port_test.sv
module bidir_pin_port_test;
    localparam logic [29:0] BASE = 30'h4000018;

    typedef struct packed {
        logic        rnw;
        logic [1:0]  sel;   // 0 value word, 1 direction word, 2 foreign word
        logic [3:0]  be;
        logic [31:0] wd;
        logic [7:0]  ext;
        logic        ack;
        logic [7:0]  rd;
        logic [7:0]  out;
        logic [7:0]  oe;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd1, 4'b0001, 32'h0000_00F0, 8'h00, 1'b1, 8'h00, 8'h00, 8'hF0}, // R4
        '{1'b0, 2'd0, 4'b0001, 32'hFFFF_FFA5, 8'h00, 1'b1, 8'h00, 8'hA5, 8'hF0}, // R3
        '{1'b1, 2'd1, 4'b1111, 32'h0,         8'h00, 1'b1, 8'hF0, 8'hA5, 8'hF0}, // R6
        '{1'b1, 2'd0, 4'b0001, 32'h0,         8'h3C, 1'b1, 8'hAC, 8'hA5, 8'hF0}, // R7
        '{1'b0, 2'd0, 4'b1110, 32'h0000_005A, 8'h3C, 1'b1, 8'h00, 8'hA5, 8'hF0}, // R5
        '{1'b0, 2'd1, 4'b0000, 32'h0000_0000, 8'h3C, 1'b1, 8'h00, 8'hA5, 8'hF0}, // R5
        '{1'b1, 2'd0, 4'b0001, 32'h0,         8'h00, 1'b1, 8'hA0, 8'hA5, 8'hF0}, // R7
        '{1'b0, 2'd2, 4'b1111, 32'h0000_00FF, 8'h00, 1'b0, 8'h00, 8'hA5, 8'hF0}, // R10
        '{1'b1, 2'd2, 4'b1111, 32'h0,         8'h00, 1'b0, 8'h00, 8'hA5, 8'hF0}, // R10
        '{1'b0, 2'd1, 4'b0001, 32'h0000_000F, 8'h00, 1'b1, 8'h00, 8'hA5, 8'h0F}, // R4
        '{1'b1, 2'd0, 4'b0001, 32'h0,         8'hC3, 1'b1, 8'hC5, 8'hA5, 8'h0F}, // R7
        '{1'b0, 2'd1, 4'b0001, 32'h0000_0000, 8'hC3, 1'b1, 8'h00, 8'hA5, 8'h00}, // R4
        '{1'b1, 2'd0, 4'b0001, 32'h0,         8'h81, 1'b1, 8'h81, 8'hA5, 8'h00}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [29:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic        rnw = 1'b1;
    logic        me = 1'b0;
    logic [31:0] rdata;
    logic        ack;
    logic [7:0]  ext_pins = '0;
    logic [7:0]  pad_in, pad_out, pad_oe;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_pins);

    bidir_pin_port uut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .be_i      (be),
        .rnw_i     (rnw),
        .me_i      (me),
        .rdata_o   (rdata),
        .ack_o     (ack),
        .pad_in_i  (pad_in),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [29:0] a, input logic r, input logic [3:0] b,
                          input logic [31:0] d, output logic got, output logic [31:0] rd,
                          output int lat);
        @(negedge clk);
        addr = a; rnw = r; be = b; wdata = d;
        @(negedge clk);
        me = 1'b1; got = 1'b0; lat = 0; rd = '0;
        repeat (6) begin
            @(negedge clk);
            lat++;
            if (ack) begin
                got = 1'b1;
                break;
            end
        end
        rd = rdata;
        me = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R8 ack falls after ME low", {31'b0, ack}, 32'h0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic        got;
        logic [31:0] rd;
        int          lat;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(ack == 1'b0,    "R1 ack",   {31'b0, ack}, 32'h0);
        check(pad_oe == 8'h0, "R1 oe",    {24'b0, pad_oe}, 32'h0);
        check(pad_out == 8'h0,"R1 out",   {24'b0, pad_out}, 32'h0);
        check(rdata == 32'h0, "R1 rdata", rdata, 32'h0);
        rst_n = 1'b1;

        // R2: bus lines active while ME low
        @(negedge clk);
        addr = BASE + 30'd1; rnw = 1'b0; be = 4'hF; wdata = 32'hFFFF_FFFF;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ack == 1'b0, "R2 no ack with ME low", {31'b0, ack}, 32'h0);
        end
        addr = BASE;
        repeat (3) @(negedge clk);
        check(pad_oe == 8'h0 && pad_out == 8'h0, "R2 regs untouched",
              {16'b0, pad_oe, pad_out}, 32'h0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ext_pins = VECS[v].ext;
            repeat (3) @(negedge clk);
            access(BASE + 30'(VECS[v].sel), VECS[v].rnw, VECS[v].be, VECS[v].wd, got, rd, lat);
            check(got == VECS[v].ack, $sformatf("R10/R8 ack vec %0d", v),
                  {31'b0, got}, {31'b0, VECS[v].ack});
            if (got)
                check(lat == 1, $sformatf("R8 ack latency vec %0d", v), 32'(lat), 32'd1);
            if (VECS[v].rnw && VECS[v].ack)
                check(rd == {24'b0, VECS[v].rd}, $sformatf("R6/R7 read vec %0d", v),
                      rd, {24'b0, VECS[v].rd});
            check(pad_out == VECS[v].out, $sformatf("R3/R5 value vec %0d", v),
                  {24'b0, pad_out}, {24'b0, VECS[v].out});
            check(pad_oe == VECS[v].oe, $sformatf("R4/R5 dir vec %0d", v),
                  {24'b0, pad_oe}, {24'b0, VECS[v].oe});
        end

        // R9: hold ME high long after acknowledge
        @(negedge clk);
        addr = BASE + 30'd1; rnw = 1'b1; be = 4'h1;
        @(negedge clk);
        me = 1'b1;
        @(negedge clk);
        check(ack == 1'b1, "R9 ack raised", {31'b0, ack}, 32'h1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(ack == 1'b1, "R9 single ack held", {31'b0, ack}, 32'h1);
        end
        me = 1'b0;
        @(negedge clk);
        check(ack == 1'b0, "R8 ack drop", {31'b0, ack}, 32'h0);
        check(rdata == 32'h0, "R9 rdata cleared on release", rdata, 32'h0);

        // R1 again: reset mid-state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(pad_out == 8'h0 && pad_oe == 8'h0, "R1 reset clears regs",
              {16'b0, pad_oe, pad_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule